// File: doc/BRIEF.md
# Fixed-point bit manipulation unit

This unit applies one bit-level operation per issue to the stored integer of a W-bit word. Each issue selects an operation with a 4-bit opcode. The operation acts on operand A, and on operand B where it needs one. It may also use a flag that marks A as two's complement, two one-based bit positions (upper and lower), a signed shift amount and a single bit value for writes. The operations cover bit read and write, field extraction, inversion, several shifts and rotates, bitwise logic, and reductions over a chosen span of bits.

The outcome is held in a register and returned zero-extended to W bits. A strobe marks the cycle in which a new outcome is present. An error flag reports a bit position that is missing or out of range, and an error always forces the outcome to zero. The unit is intended to sit beside a datapath or a sequencer that issues one command per enabled cycle.

Top module: `bitmanip_unit`

## Requirements
- R1: Bit positions run from 1 at the LSB to W at the MSB. For opcodes 0 and 1 the flag `idx_err` is raised when `idx_hi` is 0 or greater than W. For opcodes 2, 13, 14 and 15 it is raised when either position is out of that range or when `idx_lo` exceeds `idx_hi`. While the flag is set, `result` is zero. No other opcode raises it.
- R2: Opcode 0 (read) returns bit `idx_hi` of A in result bit 0, and all other result bits are zero.
- R3: Opcode 1 (write) returns A with the bit at `idx_hi` replaced by `set_val`. No other bit changes.
- R4: Opcode 2 (extract) returns bits `idx_hi` down to `idx_lo` of A, inclusive, shifted down so that bit `idx_lo` lands at result bit 0. The bits above the field are zero.
- R5: Opcode 3 returns the bitwise inverse of A.
- R6: Opcode 4 (saturating shift) shifts A left when `shamt` is positive and right when it is negative. A right shift fills with the sign when `a_signed` is set. A left shift that overflows clamps: an unsigned A clamps to all ones, and a signed A clamps to the most positive or most negative value according to its own sign.
- R7: Opcodes 5 (left) and 6 (right) are logical shifts. They take `shamt` as an unsigned amount, fill with zeros, discard the bits that leave the word, never clamp, and give zero for amounts of W or more.
- R8: Opcode 7 shifts right by the unsigned `shamt`. It fills with A's top bit when `a_signed` is set and with zeros otherwise. Amounts of W or more give all sign bits or all zeros.
- R9: Opcodes 8 (left) and 9 (right) rotate A by the unsigned `shamt` taken modulo W.
- R10: Opcodes 10, 11 and 12 return the bitwise AND, OR and XOR of A and B.
- R11: Opcodes 13, 14 and 15 return, in result bit 0, the AND, OR and XOR of A's bits `idx_lo` through `idx_hi`, inclusive.
- R12: An asynchronous active-high reset clears `result`, `valid` and `idx_err`. The outcome of an operation issued with `en` high appears on the next clock edge, with `valid` high for that one cycle. While `en` is low, all three outputs hold their values and `valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Asynchronous reset, active high |
| en | input | 1 | Issues the operation presented in this cycle |
| op | input | 4 | Opcode, 0 to 15 as listed in the requirements |
| a | input | W | Operand A |
| b | input | W | Operand B, used by the bitwise logic opcodes |
| a_signed | input | 1 | Marks A as two's complement |
| idx_hi | input | IW | Upper one-based bit position |
| idx_lo | input | IW | Lower one-based bit position |
| shamt | input | SW | Shift or rotate amount; signed for opcode 4, unsigned for the others |
| set_val | input | 1 | Value written by opcode 1 |
| result | output | W | Registered outcome, zero-extended |
| valid | output | 1 | One-cycle strobe that marks a new outcome |
| idx_err | output | 1 | Bit-position error for the last issued operation |

## Verification
Each issue is independent and the only state is the output register. A fault in the datapath therefore shows up on the strobe cycle of the first command that exercises the faulty path, one edge after the issue. The saturation boundary, the sign fill for amounts at or past W, rotate wrap-around, an inverted position range and positions 0 and W+1 are the cases where a fault is most likely to stay hidden. The bench drives each of these directly and then adds a long random mix. A fault in the register or the enable shows instead as a strobe without a matching outcome, or as a result that changes while `en` is low.

// File: rtl/bm_pkg.sv
package bm_pkg;
   typedef enum logic [3:0] {
      OP_GET    = 4'd0,
      OP_SET    = 4'd1,
      OP_SLICE  = 4'd2,
      OP_NOT    = 4'd3,
      OP_SHIFT  = 4'd4,
      OP_SLL    = 4'd5,
      OP_SRL    = 4'd6,
      OP_SRA    = 4'd7,
      OP_ROL    = 4'd8,
      OP_ROR    = 4'd9,
      OP_AND    = 4'd10,
      OP_OR     = 4'd11,
      OP_XOR    = 4'd12,
      OP_REDAND = 4'd13,
      OP_REDOR  = 4'd14,
      OP_REDXOR = 4'd15
   } bm_op_e;

   function automatic logic is_shift_class(bm_op_e o);
      return (o == OP_SHIFT) || (o == OP_SLL) || (o == OP_SRL) ||
             (o == OP_SRA) || (o == OP_ROL) || (o == OP_ROR);
   endfunction
endpackage

// File: rtl/bm_index_check.sv
module bm_index_check
   import bm_pkg::*;
#(
   parameter int W  = 8,
   parameter int IW = $clog2(W) + 1
) (
   input  bm_op_e          op,
   input  logic [IW-1:0]   idx_hi,
   input  logic [IW-1:0]   idx_lo,
   output logic            err
);
   localparam logic [IW-1:0] TOP_POS = IW'(W);

   logic hi_bad, lo_bad, one_pos, span;

   assign hi_bad  = (idx_hi == '0) || (idx_hi > TOP_POS);
   assign lo_bad  = (idx_lo == '0) || (idx_lo > TOP_POS);
   assign one_pos = (op == OP_GET) || (op == OP_SET);
   assign span    = (op == OP_SLICE) || (op == OP_REDAND) ||
                    (op == OP_REDOR) || (op == OP_REDXOR);

   always_comb begin
      if (one_pos)   err = hi_bad;
      else if (span) err = hi_bad || lo_bad || (idx_lo > idx_hi);
      else           err = 1'b0;
   end
endmodule

// File: rtl/bm_shifter.sv
module bm_shifter
   import bm_pkg::*;
#(
   parameter int W  = 8,
   parameter int SW = $clog2(W) + 2
) (
   input  bm_op_e               op,
   input  logic [W-1:0]         a,
   input  logic                 a_signed,
   input  logic signed [SW-1:0] shamt,
   output logic [W-1:0]         y
);
   localparam int EW = 3 * W;
   localparam int LW = (W > 2) ? $clog2(W) : 1;

   logic [EW-1:0]  ext, left, right;
   logic [SW:0]    neg_amt;
   logic [SW-1:0]  uamt;
   logic           ovf;
   logic [W-1:0]   sat, gen_y, sra_y;
   logic [LW-1:0]  rot;
   logic [2*W-1:0] rl, rr;

   assign uamt    = $unsigned(shamt);
   assign neg_amt = $unsigned(-($signed({shamt[SW-1], shamt})));
   assign ext     = a_signed ? {{(2*W){a[W-1]}}, a} : {{(2*W){1'b0}}, a};
   assign left    = ext << uamt;
   assign right   = $unsigned($signed(ext) >>> neg_amt);

   // overflow: bits above the kept field disagree with the kept result
   always_comb begin
      if (a_signed)
         ovf = !((&left[EW-1:W-1]) || !(|left[EW-1:W-1]));
      else
         ovf = |left[EW-1:W];
      if (!a_signed)     sat = '1;
      else if (a[W-1])   sat = {1'b1, {(W-1){1'b0}}};
      else               sat = {1'b0, {(W-1){1'b1}}};
   end

   always_comb begin
      if (shamt[SW-1]) gen_y = right[W-1:0];
      else if (ovf)    gen_y = sat;
      else             gen_y = left[W-1:0];
   end

   assign sra_y = a_signed ? W'($signed(a) >>> uamt) : (a >> uamt);

   generate
      if ((W & (W - 1)) == 0) begin : g_pow2_mod
         assign rot = uamt[LW-1:0];
      end else begin : g_div_mod
         assign rot = LW'(uamt % SW'(W));
      end
   endgenerate

   assign rl = {a, a} << rot;
   assign rr = {a, a} >> rot;

   always_comb begin
      case (op)
         OP_SHIFT: y = gen_y;
         OP_SLL:   y = a << uamt;
         OP_SRL:   y = a >> uamt;
         OP_SRA:   y = sra_y;
         OP_ROL:   y = rl[2*W-1:W];
         OP_ROR:   y = rr[W-1:0];
         default:  y = '0;
      endcase
   end

   always_comb begin
      if ((op == OP_ROL) || (op == OP_ROR))
         assert_rotate_keeps_ones_R9: assert ($countones(y) == $countones(a));
      if ((op == OP_SHIFT) && !a_signed && !shamt[SW-1])
         assert_unsigned_sat_monotone_R6: assert (y >= a);
   end
endmodule

// File: rtl/bm_logic.sv
module bm_logic
   import bm_pkg::*;
#(
   parameter int W  = 8,
   parameter int IW = $clog2(W) + 1
) (
   input  bm_op_e        op,
   input  logic [W-1:0]  a,
   input  logic [W-1:0]  b,
   input  logic          set_val,
   input  logic [IW-1:0] idx_hi,
   input  logic [IW-1:0] idx_lo,
   output logic [W-1:0]  y
);
   logic [W-1:0] one_mask, span_mask, span_bits;

   assign one_mask = W'(1) << (idx_hi - IW'(1));

   generate
      for (genvar i = 0; i < W; i++) begin : g_span
         assign span_mask[i] = (IW'(i + 1) >= idx_lo) && (IW'(i + 1) <= idx_hi);
      end
   endgenerate

   assign span_bits = a & span_mask;

   always_comb begin
      case (op)
         OP_GET:    y = {{(W-1){1'b0}}, |(a & one_mask)};
         OP_SET:    y = set_val ? (a | one_mask) : (a & ~one_mask);
         OP_SLICE:  y = span_bits >> (idx_lo - IW'(1));
         OP_NOT:    y = ~a;
         OP_AND:    y = a & b;
         OP_OR:     y = a | b;
         OP_XOR:    y = a ^ b;
         OP_REDAND: y = {{(W-1){1'b0}}, &(a | ~span_mask)};
         OP_REDOR:  y = {{(W-1){1'b0}}, |span_bits};
         OP_REDXOR: y = {{(W-1){1'b0}}, ^span_bits};
         default:   y = '0;
      endcase
   end

   always_comb begin
      if (op == OP_SET)
         assert_set_touches_one_bit_R3: assert ($countones(y ^ a) <= 1);
   end
endmodule

// File: rtl/bitmanip_unit.sv
module bitmanip_unit
   import bm_pkg::*;
#(
   parameter int W  = 8,
   parameter int IW = $clog2(W) + 1,
   parameter int SW = $clog2(W) + 2
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 en,
   input  logic [3:0]           op,
   input  logic [W-1:0]         a,
   input  logic [W-1:0]         b,
   input  logic                 a_signed,
   input  logic [IW-1:0]        idx_hi,
   input  logic [IW-1:0]        idx_lo,
   input  logic signed [SW-1:0] shamt,
   input  logic                 set_val,
   output logic [W-1:0]         result,
   output logic                 valid,
   output logic                 idx_err
);
   generate
      if (W < 2) begin : g_chk_w
         $error("bitmanip_unit: W must be at least 2");
      end
      if ((1 << IW) <= W) begin : g_chk_iw
         $error("bitmanip_unit: IW too narrow to hold position W");
      end
      if ((1 << (SW - 1)) <= W) begin : g_chk_sw
         $error("bitmanip_unit: SW too narrow to express an amount of W");
      end
   endgenerate

   bm_op_e       opc;
   logic         err_c;
   logic [W-1:0] sh_y, lg_y, next_y;

   assign opc = bm_op_e'(op);

   bm_index_check #(.W(W), .IW(IW)) u_index (
      .op(opc), .idx_hi(idx_hi), .idx_lo(idx_lo), .err(err_c)
   );

   bm_shifter #(.W(W), .SW(SW)) u_shift (
      .op(opc), .a(a), .a_signed(a_signed), .shamt(shamt), .y(sh_y)
   );

   bm_logic #(.W(W), .IW(IW)) u_logic (
      .op(opc), .a(a), .b(b), .set_val(set_val),
      .idx_hi(idx_hi), .idx_lo(idx_lo), .y(lg_y)
   );

   always_comb begin
      if (err_c)                    next_y = '0;
      else if (is_shift_class(opc)) next_y = sh_y;
      else                          next_y = lg_y;
   end

   always_ff @(posedge clk or posedge rst) begin
      if (rst) begin
         result  <= '0;
         valid   <= 1'b0;
         idx_err <= 1'b0;
      end else begin
         valid <= en;
         if (en) begin
            result  <= next_y;
            idx_err <= err_c;
         end
      end
   end

   assert_strobe_after_issue_R12: assert property (
      @(posedge clk) disable iff (rst) en |=> valid);
   assert_no_strobe_when_idle_R12: assert property (
      @(posedge clk) disable iff (rst) !en |=> !valid);
   assert_hold_when_idle_R12: assert property (
      @(posedge clk) disable iff (rst) !en |=> ($stable(result) && $stable(idx_err)));
   assert_error_zeroes_result_R1: assert property (
      @(posedge clk) disable iff (rst) idx_err |-> (result == '0));
   assert_zero_position_flagged_R1: assert property (
      @(posedge clk) disable iff (rst)
      (en && (op == 4'd0) && (idx_hi == '0)) |=> idx_err);
endmodule

// File: tb/test_bitmanip_unit.sv
module test_bitmanip_unit;
   localparam int W  = 8;
   localparam int IW = 4;
   localparam int SW = 5;

   typedef struct {
      logic [W-1:0] r;
      logic         e;
      int           op;
      string        req;
   } item_t;

   logic clk = 1'b0, rst = 1'b1, en = 1'b0, a_signed = 1'b0, set_val = 1'b0;
   logic [3:0] op = '0;
   logic [W-1:0] a = '0, b = '0;
   logic [IW-1:0] idx_hi = '0, idx_lo = '0;
   logic signed [SW-1:0] shamt = '0;
   logic [W-1:0] result;
   logic valid, idx_err;

   int compared = 0, mismatched = 0;
   item_t sb[$];

   always #5 clk = ~clk;

   bitmanip_unit #(.W(W), .IW(IW), .SW(SW)) i_bitmanip_unit (
      .clk(clk), .rst(rst), .en(en), .op(op), .a(a), .b(b),
      .a_signed(a_signed), .idx_hi(idx_hi), .idx_lo(idx_lo),
      .shamt(shamt), .set_val(set_val),
      .result(result), .valid(valid), .idx_err(idx_err)
   );

   function automatic string req_of(int o, logic e);
      if (e) return "R1";
      case (o)
         0: return "R2";  1: return "R3";  2: return "R4";  3: return "R5";
         4: return "R6";  5, 6: return "R7"; 7: return "R8";
         8, 9: return "R9"; 10, 11, 12: return "R10";
         default: return "R11";
      endcase
   endfunction

   // behavioural model written bit by bit from the requirements
   function automatic item_t model(int o, logic [W-1:0] av, logic [W-1:0] bv,
                                   logic sg, int hi, int lo, int sh, logic sv);
      item_t it;
      int amt;
      longint v;
      it.r = '0; it.e = 1'b0; it.op = o;
      amt = sh & 31;
      if (o <= 1) it.e = (hi < 1 || hi > W);
      if (o == 2 || o >= 13) it.e = (hi < 1 || hi > W || lo < 1 || lo > W || lo > hi);
      if (!it.e) begin
         case (o)
            0: it.r[0] = av[hi-1];
            1: begin it.r = av; it.r[hi-1] = sv; end
            2: for (int i = lo; i <= hi; i++) it.r[i-lo] = av[i-1];
            3: for (int i = 0; i < W; i++) it.r[i] = !av[i];
            4: begin
               v = sg ? longint'($signed(av)) : longint'(av);
               if (sh >= 0) begin
                  v = v * (longint'(1) << sh);
                  if (sg && v > 127) v = 127;
                  if (sg && v < -128) v = -128;
                  if (!sg && v > 255) v = 255;
               end else v = v >>> (-sh);
               it.r = v[W-1:0];
            end
            5: for (int i = 0; i < W; i++) it.r[i] = (i - amt >= 0) ? av[i-amt] : 1'b0;
            6: for (int i = 0; i < W; i++) it.r[i] = (i + amt < W) ? av[i+amt] : 1'b0;
            7: for (int i = 0; i < W; i++) it.r[i] = (i + amt < W) ? av[i+amt] : (sg & av[W-1]);
            8: for (int i = 0; i < W; i++) it.r[(i + amt) % W] = av[i];
            9: for (int i = 0; i < W; i++) it.r[i] = av[(i + amt) % W];
            10: it.r = av & bv;
            11: it.r = av | bv;
            12: it.r = av ^ bv;
            default: begin
               it.r[0] = (o == 13) ? 1'b1 : 1'b0;
               for (int i = lo; i <= hi; i++) begin
                  if (o == 13) it.r[0] = it.r[0] & av[i-1];
                  if (o == 14) it.r[0] = it.r[0] | av[i-1];
                  if (o == 15) it.r[0] = it.r[0] ^ av[i-1];
               end
            end
         endcase
      end
      it.req = req_of(o, it.e);
      return it;
   endfunction

   task automatic issue(int o, logic [W-1:0] av, logic [W-1:0] bv, logic sg,
                        int hi, int lo, int sh, logic sv);
      @(negedge clk);
      op = 4'(o); a = av; b = bv; a_signed = sg;
      idx_hi = IW'(hi); idx_lo = IW'(lo); shamt = SW'(sh); set_val = sv;
      en = 1'b1;
      sb.push_back(model(o, av, bv, sg, hi, lo, sh, sv));
   endtask

   task automatic check(string req, string what, int act, int exp);
      compared++;
      if (act != exp) begin
         mismatched++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   // monitor: pops one expected item per strobe
   always @(negedge clk) begin
      if (!rst && valid) begin
         if (sb.size() == 0) check("R12", "strobe without issue", 1, 0);
         else begin
            item_t it;
            it = sb.pop_front();
            check(it.req, $sformatf("op %0d result", it.op), int'(result), int'(it.r));
            check(it.req, $sformatf("op %0d idx_err", it.op), int'(idx_err), int'(it.e));
         end
      end
   end

   initial begin
      #(200000 * 10);
      check("R12", "watchdog expired", 1, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end

   initial begin
      logic [W-1:0] held;
      repeat (3) @(negedge clk);
      check("R12", "reset result", int'(result), 0);
      check("R12", "reset valid", int'(valid), 0);
      check("R12", "reset idx_err", int'(idx_err), 0);
      rst = 1'b0;
      // R2 read, R3 write, R4 extract
      issue(0, 8'h55, 0, 0, 2, 0, 0, 0);
      issue(0, 8'h55, 0, 0, 8, 0, 0, 0);
      issue(1, 8'h05, 0, 0, 2, 0, 0, 1);
      issue(1, 8'h07, 0, 0, 1, 0, 0, 0);
      issue(1, 8'h80, 0, 0, 8, 0, 0, 0);
      issue(2, 8'h55, 0, 0, 8, 3, 0, 0);
      issue(2, 8'hA5, 0, 0, 8, 8, 0, 0);
      // R1 bad positions
      issue(0, 8'hFF, 0, 0, 0, 0, 0, 0);
      issue(1, 8'hFF, 0, 0, 9, 0, 0, 1);
      issue(2, 8'hFF, 0, 0, 3, 5, 0, 0);
      issue(14, 8'hFF, 0, 0, 9, 1, 0, 0);
      issue(3, 8'h05, 0, 0, 0, 0, 0, 0);
      // R6 saturating shift
      issue(4, 8'h40, 0, 0, 0, 0, 2, 0);
      issue(4, 8'h04, 0, 0, 0, 0, 1, 0);
      issue(4, 8'h20, 0, 1, 0, 0, 2, 0);
      issue(4, 8'hC0, 0, 1, 0, 0, 1, 0);
      issue(4, 8'hB0, 0, 1, 0, 0, 1, 0);
      issue(4, 8'h0A, 0, 0, 0, 0, -1, 0);
      issue(4, 8'h80, 0, 1, 0, 0, -16, 0);
      issue(4, 8'h00, 0, 1, 0, 0, 15, 0);
      // R7, R8
      issue(5, 8'hAA, 0, 0, 0, 0, 1, 0);
      issue(5, 8'hAA, 0, 0, 0, 0, 8, 0);
      issue(6, 8'h80, 0, 1, 0, 0, 1, 0);
      issue(7, 8'h80, 0, 1, 0, 0, 1, 0);
      issue(7, 8'h80, 0, 0, 0, 0, 1, 0);
      issue(7, 8'h90, 0, 1, 0, 0, 20, 0);
      // R9 rotates incl. wrap past W
      issue(8, 8'h0A, 0, 0, 0, 0, 1, 0);
      issue(9, 8'h05, 0, 0, 0, 0, 1, 0);
      issue(8, 8'h81, 0, 0, 0, 0, 9, 0);
      issue(9, 8'h81, 0, 0, 0, 0, 8, 0);
      // R10, R11
      issue(10, 8'h05, 8'h0A, 0, 0, 0, 0, 0);
      issue(11, 8'h05, 8'h0A, 0, 0, 0, 0, 0);
      issue(12, 8'h5C, 8'h3A, 0, 0, 0, 0, 0);
      issue(13, 8'h05, 0, 0, 2, 1, 0, 0);
      issue(15, 8'h05, 0, 0, 4, 3, 0, 0);
      issue(14, 8'h05, 0, 0, 8, 1, 0, 0);
      issue(13, 8'hF0, 0, 0, 8, 5, 0, 0);
      // random mix
      for (int k = 0; k < 400; k++)
         issue(int'($urandom_range(0, 15)), W'($urandom), W'($urandom),
               1'($urandom), int'($urandom_range(0, 15)), int'($urandom_range(0, 15)),
               int'($urandom_range(0, 31)) - 16, 1'($urandom));
      @(negedge clk);
      en = 1'b0;
      @(negedge clk);
      held = result;
      // R12: inputs move while en is low; outputs must not
      op = 4'd3; a = 8'h3C;
      repeat (3) @(negedge clk);
      check("R12", "result held while idle", int'(result), int'(held));
      check("R12", "strobe low while idle", int'(valid), 0);
      check("R12", "all issues answered", sb.size(), 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end
endmodule